// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a small serial sampling converter that has only three wires: an active-low select, a serial clock and one data return line. A start request makes the block lower the select line, which is the sampling instant of the converter. The block then runs a fixed-length burst of serial clocks and collects the returned bits, MSB first. Each frame carries four leading zeros, then the result, then enough trailing zeros to fill sixteen clocks. The block strips that framing and presents the result on a parallel bus with a one-cycle valid strobe. A result comes from the sample taken at the select fall of its own frame.

The result width is a parameter (12, 10 or 8 bits). For the narrower widths, a control input asks for a 15-clock frame, which drops the last trailing zero. A power-down request runs a frame that is cut short after a fixed number of clocks, and that frame gives no result. A wake request then runs one full dummy frame, whose content is thrown away. Requests that arrive while a frame is in progress are held and served once the line has been quiet for the programmed time.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, select and serial clock are high, and busy, valid, framing error and asleep are all low.
- R2: A start request produces one frame: select falls, then exactly 16 serial-clock falling edges, then select rises. The serial clock is high whenever select is high.
- R3: Frame bit k is the level on the data line before the k-th serial-clock fall, where bit 0 is the level present when select falls. The result is frame bits 4 to 4+RES_BITS-1, bit 4 being the result MSB. It appears on the data output with a one-cycle valid strobe after select rises.
- R4: If any of frame bits 0 to 3 is 1, the framing-error output is high in the same cycle as the valid strobe; otherwise it is low.
- R5: When RES_BITS is below 12 and the short-frame input is high at frame launch, the frame has 15 serial-clock falls and returns the same result. With RES_BITS of 12 the input has no effect.
- R6: A power-down request runs a frame of PD_CLKS serial-clock falls (default 4, legal range 3 to 9). That frame raises no valid strobe, and asleep goes high when it ends.
- R7: While asleep, start and power-down requests are dropped: select stays high and no valid strobe appears.
- R8: A wake request while asleep runs one full 16-clock dummy frame with no valid strobe, then clears asleep. The next start returns valid data.
- R9: Between the rise of select and the next fall, at least QUIET_CYC system clocks pass.
- R10: A start request that arrives while a frame is running is held and served after that frame, giving a second result.
- R11: Each serial-clock low phase lasts CLK_DIV/2 system clocks (50% duty).
- R12: A power-down request pending together with a start request is served first, and the start is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| pdn_req_i | input | 1 | Request entry into power-down |
| wake_req_i | input | 1 | Request wake-up from power-down |
| short_frame_i | input | 1 | Use a 15-clock frame (RES_BITS below 12 only) |
| sdata_i | input | 1 | Serial data from the converter |
| csn_o | output | 1 | Active-low select; its fall is the sampling instant |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | A frame or its closing cycle is in progress |
| data_o | output | RES_BITS | Last conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | A leading zero read back as 1 (with valid) |
| asleep_o | output | 1 | Converter is in power-down |

## Verification
The result path is driven with an all-ones word, an all-zeros word, two alternating bit patterns and a lone MSB. All-ones and all-zeros catch a fixed or inverted bit, the alternating pairs catch a one-position shift or a swapped order, and the lone MSB shows whether the first captured bit lands in the top result bit. The same data is then returned with leading ones, which must raise the framing error but leave the result alone. A short frame with all ones in the result shows whether the 15-clock frame still collects every result bit. A request sequence of power-down, ignored starts, wake and a fresh start checks the clock counts of the abort and dummy frames and that neither raises a strobe.

// File: rtl/serial_adc_reader_pkg.sv
// Shared types for the serial ADC readout controller.
// Assumes a 16-clock frame with four leading zeros.
package serial_adc_reader_pkg;

    localparam int FRAME_LEN  = 16;
    localparam int LEAD_ZEROS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        FR_CONV,
        FR_ABORT,
        FR_DUMMY
    } frame_kind_t;

endpackage

// File: rtl/serial_adc_reader_tick.sv
// Half-period timer for the serial clock.
// Counts while enabled and pulses tick every HALF system clocks.
// Assumes HALF >= 1; the count restarts from zero whenever enable drops.
module serial_adc_reader_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == CW'(HALF - 1));

    // Advance the phase counter, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/serial_adc_reader_seq.sv
// Frame sequencer: holds requests, enforces the quiet time, launches
// conversion, power-down abort and wake dummy frames, and drives select
// and serial clock. Data is sampled just before each serial-clock fall.
// Assumes a converter that moves to the next bit on each serial-clock fall.
module serial_adc_reader_seq
    import serial_adc_reader_pkg::*;
#(
    parameter int HALF      = 2,
    parameter int QUIET_CYC = 8,
    parameter int PD_CLKS   = 4,
    parameter bit SHORT_OK  = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          pdn_req_i,
    input  logic                          wake_req_i,
    input  logic                          short_frame_i,
    output logic                          csn_o,
    output logic                          sclk_o,
    output logic                          busy_o,
    output logic                          asleep_o,
    output logic                          cap_clr_o,
    output logic                          cap_en_o,
    output logic [$clog2(FRAME_LEN)-1:0]  cap_idx_o,
    output logic                          done_conv_o
);
    localparam int BW = $clog2(FRAME_LEN);
    localparam int NW = BW + 1;
    localparam int QW = $clog2(QUIET_CYC + 2);
    localparam logic [NW-1:0] NCLK_FULL  = NW'(FRAME_LEN);
    localparam logic [NW-1:0] NCLK_SHORT = NW'(FRAME_LEN - 1);
    localparam logic [NW-1:0] NCLK_PD    = NW'(PD_CLKS);

    seq_state_t    state_q;
    frame_kind_t   kind_q;
    frame_kind_t   launch_kind;
    logic [BW-1:0] bitcnt_q;
    logic [NW-1:0] nclk_q;
    logic [QW-1:0] qcnt_q;
    logic          asleep_q;
    logic          pend_start_q, pend_pdn_q, pend_wake_q;
    logic          tick, quiet_ok, launch, last_bit, in_frame;

    serial_adc_reader_tick #(.HALF(HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (in_frame),
        .tick_o (tick)
    );

    assign in_frame = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign quiet_ok = (qcnt_q >= QW'(QUIET_CYC));
    assign last_bit = ({1'b0, bitcnt_q} == (nclk_q - 1'b1));

    // Pick which pending request a launch would serve (wake, then power-down, then start).
    always_comb begin
        launch = 1'b0;
        launch_kind = FR_CONV;
        if (state_q == ST_IDLE && quiet_ok) begin
            if (asleep_q) begin
                launch = pend_wake_q;
                launch_kind = FR_DUMMY;
            end else if (pend_pdn_q) begin
                launch = 1'b1;
                launch_kind = FR_ABORT;
            end else if (pend_start_q) begin
                launch = 1'b1;
                launch_kind = FR_CONV;
            end
        end
    end

    // Hold requests until served; drop those that do not apply to the power state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_start_q <= 1'b0;
            pend_pdn_q   <= 1'b0;
            pend_wake_q  <= 1'b0;
        end else begin
            pend_start_q <= !asleep_q && !(launch && launch_kind == FR_ABORT)
                            && ((pend_start_q && !(launch && launch_kind == FR_CONV)) || start_i);
            pend_pdn_q   <= !asleep_q
                            && ((pend_pdn_q && !(launch && launch_kind == FR_ABORT)) || pdn_req_i);
            pend_wake_q  <= asleep_q
                            && ((pend_wake_q && !(launch && launch_kind == FR_DUMMY)) || wake_req_i);
        end
    end

    // Count quiet cycles with select high, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qcnt_q <= '0;
        end else if (state_q == ST_DONE) begin
            qcnt_q <= '0;
        end else if (state_q == ST_IDLE && !quiet_ok) begin
            qcnt_q <= qcnt_q + 1'b1;
        end
    end

    // Main frame state machine and clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= FR_CONV;
            bitcnt_q <= '0;
            nclk_q   <= NCLK_FULL;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        state_q  <= ST_SETUP;
                        kind_q   <= launch_kind;
                        bitcnt_q <= '0;
                        if (launch_kind == FR_ABORT) begin
                            nclk_q <= NCLK_PD;
                        end else if (launch_kind == FR_CONV && SHORT_OK && short_frame_i) begin
                            nclk_q <= NCLK_SHORT;
                        end else begin
                            nclk_q <= NCLK_FULL;
                        end
                    end
                end
                ST_SETUP: if (tick) state_q <= ST_LOW;
                ST_LOW:   if (tick) state_q <= ST_HIGH;
                ST_HIGH: begin
                    if (tick) begin
                        if (last_bit) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q  <= ST_LOW;
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Update the power state when an abort or a dummy frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep_q <= 1'b0;
        end else if (state_q == ST_DONE && kind_q == FR_ABORT) begin
            asleep_q <= 1'b1;
        end else if (state_q == ST_DONE && kind_q == FR_DUMMY) begin
            asleep_q <= 1'b0;
        end
    end

    assign csn_o       = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign sclk_o      = (state_q != ST_LOW);
    assign busy_o      = (state_q != ST_IDLE);
    assign asleep_o    = asleep_q;
    assign cap_clr_o   = launch;
    assign cap_en_o    = tick && ((state_q == ST_SETUP) || (state_q == ST_HIGH && !last_bit));
    assign cap_idx_o   = (state_q == ST_SETUP) ? '0 : (bitcnt_q + 1'b1);
    assign done_conv_o = (state_q == ST_DONE) && (kind_q == FR_CONV);

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> ({1'b0, bitcnt_q} < nclk_q));

    // R9
    quiet_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && $past(state_q) == ST_IDLE) |-> $past(quiet_ok));

    // R7
    asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && asleep_q && !pend_wake_q) |=> (state_q != ST_SETUP));

endmodule

// File: rtl/serial_adc_reader_capture.sv
// Capture unit: stores each sampled bit at its frame position, then strips
// the framing zeros and registers the result with its valid strobe.
// Assumes the bit index runs 0..FRAME_LEN-1 with bit 0 first on the line.
module serial_adc_reader_capture
    import serial_adc_reader_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         en_i,
    input  logic [$clog2(FRAME_LEN)-1:0] idx_i,
    input  logic                         sdata_i,
    input  logic                         done_i,
    output logic [RES_BITS-1:0]          data_o,
    output logic                         valid_o,
    output logic                         frame_err_o
);
    localparam int BW      = $clog2(FRAME_LEN);
    localparam int TOP     = FRAME_LEN - 1;
    localparam int DATA_HI = FRAME_LEN - 1 - LEAD_ZEROS;

    logic [FRAME_LEN-1:0] frame_q;
    logic                 lead_bad;

    assign lead_bad = |frame_q[TOP -: LEAD_ZEROS];

    // Place each sampled bit at its position in the frame, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            frame_q <= '0;
        end else if (en_i) begin
            frame_q[BW'(TOP) - idx_i] <= sdata_i;
        end
    end

    // Extract the result and flag bad leading zeros when a conversion closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o      <= '0;
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o     <= done_i;
            frame_err_o <= done_i && lead_bad;
            if (done_i) begin
                data_o <= frame_q[DATA_HI -: RES_BITS];
            end
        end
    end

    // R4
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> valid_o);

endmodule

// File: rtl/serial_adc_reader.sv
// Serial ADC readout controller top: sequencer plus capture unit.
// Assumes CLK_DIV even and >= 2, RES_BITS of 12, 10 or 8, PD_CLKS in 3..9.
module serial_adc_reader #(
    parameter int RES_BITS  = 10,
    parameter int CLK_DIV   = 4,
    parameter int QUIET_CYC = 8,
    parameter int PD_CLKS   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                pdn_req_i,
    input  logic                wake_req_i,
    input  logic                short_frame_i,
    input  logic                sdata_i,
    output logic                csn_o,
    output logic                sclk_o,
    output logic                busy_o,
    output logic [RES_BITS-1:0] data_o,
    output logic                valid_o,
    output logic                frame_err_o,
    output logic                asleep_o
);
    import serial_adc_reader_pkg::*;

    localparam int HALF     = CLK_DIV / 2;
    localparam bit SHORT_OK = (RES_BITS < 12);
    localparam int BW       = $clog2(FRAME_LEN);

    logic          cap_clr, cap_en, done_conv;
    logic [BW-1:0] cap_idx;

    serial_adc_reader_seq #(
        .HALF      (HALF),
        .QUIET_CYC (QUIET_CYC),
        .PD_CLKS   (PD_CLKS),
        .SHORT_OK  (SHORT_OK)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .pdn_req_i     (pdn_req_i),
        .wake_req_i    (wake_req_i),
        .short_frame_i (short_frame_i),
        .csn_o         (csn_o),
        .sclk_o        (sclk_o),
        .busy_o        (busy_o),
        .asleep_o      (asleep_o),
        .cap_clr_o     (cap_clr),
        .cap_en_o      (cap_en),
        .cap_idx_o     (cap_idx),
        .done_conv_o   (done_conv)
    );

    serial_adc_reader_capture #(
        .RES_BITS (RES_BITS)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (cap_clr),
        .en_i        (cap_en),
        .idx_i       (cap_idx),
        .sdata_i     (sdata_i),
        .done_i      (done_conv),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o)
    );

    // R6
    no_strobe_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !asleep_o);

    // R2
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_o) |-> sclk_o);

endmodule

// File: tb/serial_adc_reader_bench.sv
`timescale 1ns/1ps
module serial_adc_reader_bench;
    localparam int RES   = 10;
    localparam int DIV   = 4;
    localparam int QUIET = 6;
    localparam int PDC   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, pdn_req_i = 1'b0, wake_req_i = 1'b0, short_frame_i = 1'b0;
    logic sdata_i;
    logic csn_o, sclk_o, busy_o, valid_o, frame_err_o, asleep_o;
    logic [RES-1:0] data_o;

    serial_adc_reader #(.RES_BITS(RES), .CLK_DIV(DIV), .QUIET_CYC(QUIET), .PD_CLKS(PDC))
    u_serial_adc_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pdn_req_i(pdn_req_i),
        .wake_req_i(wake_req_i), .short_frame_i(short_frame_i), .sdata_i(sdata_i),
        .csn_o(csn_o), .sclk_o(sclk_o), .busy_o(busy_o), .data_o(data_o),
        .valid_o(valid_o), .frame_err_o(frame_err_o), .asleep_o(asleep_o)
    );

    always #4 clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    logic [15:0] dev_word = 16'h0;
    int idx = 0, falls_cur = 0, last_falls = 0, csn_falls = 0;
    int t_fall = 0, t_cs_rise = 0, bad_width = 0, bad_quiet = 0;
    int vcnt = 0;
    logic [RES-1:0] last_data = '0;
    logic last_err = 1'b0;
    bit done = 0;

    always @(posedge clk) cyc++;

    // Converter model: bit 0 on the line at select fall, next bit on each clock fall.
    assign sdata_i = (idx < 16) ? dev_word[15 - idx] : 1'b0;
    always @(negedge csn_o) begin
        idx = 0; falls_cur = 0; csn_falls++;
        if (cyc - t_cs_rise < QUIET && t_cs_rise > 0) bad_quiet++;
    end
    always @(posedge csn_o) begin
        last_falls = falls_cur; t_cs_rise = cyc;
    end
    always @(negedge sclk_o) if (csn_o === 1'b0) begin
        idx++; falls_cur++; t_fall = cyc;
    end
    always @(posedge sclk_o) if (csn_o === 1'b0) begin
        if (cyc - t_fall != DIV / 2) bad_width++;
    end
    always @(negedge clk) if (rst_n && valid_o) begin
        vcnt++; last_data = data_o; last_err = frame_err_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic wait_vcnt(input int target);
        for (int i = 0; i < 600 && vcnt < target; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600 && busy_o; i++) @(negedge clk);
        repeat (QUIET + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(csn_o == 1 && sclk_o == 1, "R1 select/clock", {csn_o, sclk_o}, 3);
        chk(!busy_o && !valid_o && !frame_err_o && !asleep_o, "R1 status",
            {busy_o, valid_o, frame_err_o, asleep_o}, 0);
    endtask

    task automatic t_conv(input logic [RES-1:0] d, input logic [3:0] lead,
                          input logic shrt, input string req);
        int v0 = vcnt;
        dev_word = {lead, d, 2'b00};
        short_frame_i = shrt;
        pulse(start_i);
        wait_vcnt(v0 + 1);
        chk(vcnt == v0 + 1, {req, " R2 one strobe"}, vcnt - v0, 1);
        chk(last_data == d, {req, " R3 data"}, last_data, d);
        chk(last_err == (|lead), {req, " R4 framing error"}, last_err, |lead);
        chk(last_falls == (shrt ? 15 : 16), {req, " R2/R5 clock count"}, last_falls, shrt ? 15 : 16);
        wait_idle();
        short_frame_i = 1'b0;
    endtask

    task automatic t_held();
        int v0 = vcnt;
        dev_word = {4'b0, 10'h2C7, 2'b00};
        pulse(start_i);
        for (int i = 0; i < 200 && csn_o; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        pulse(start_i);
        wait_vcnt(v0 + 2);
        chk(vcnt == v0 + 2, "R10 held start served", vcnt - v0, 2);
        chk(last_data == 10'h2C7, "R10 second data", last_data, 10'h2C7);
        wait_idle();
    endtask

    task automatic t_pdn();
        int v0 = vcnt;
        pulse(pdn_req_i);
        for (int i = 0; i < 400 && !asleep_o; i++) @(negedge clk);
        wait_idle();
        chk(asleep_o == 1, "R6 asleep", asleep_o, 1);
        chk(last_falls == PDC, "R6 abort clock count", last_falls, PDC);
        chk(vcnt == v0, "R6 no strobe", vcnt - v0, 0);
    endtask

    task automatic t_asleep_ignore();
        int v0 = vcnt, c0 = csn_falls;
        pulse(start_i);
        pulse(pdn_req_i);
        repeat (120) @(negedge clk);
        chk(csn_falls == c0, "R7 no frame while asleep", csn_falls - c0, 0);
        chk(vcnt == v0 && asleep_o, "R7 still asleep, no strobe", vcnt - v0, 0);
    endtask

    task automatic t_wake();
        int v0 = vcnt;
        dev_word = {4'b0, 10'h155, 2'b00};
        pulse(wake_req_i);
        for (int i = 0; i < 400 && asleep_o; i++) @(negedge clk);
        wait_idle();
        chk(!asleep_o, "R8 awake", asleep_o, 0);
        chk(last_falls == 16, "R8 dummy clock count", last_falls, 16);
        chk(vcnt == v0, "R8 dummy discarded", vcnt - v0, 0);
        t_conv(10'h0F3, 4'h0, 1'b0, "R8 first after wake");
    endtask

    task automatic t_priority();
        int v0 = vcnt;
        // Both requests in the same cycle: power-down wins, start is dropped (R12).
        @(negedge clk) begin start_i = 1'b1; pdn_req_i = 1'b1; end
        @(negedge clk) begin start_i = 1'b0; pdn_req_i = 1'b0; end
        for (int i = 0; i < 400 && !asleep_o; i++) @(negedge clk);
        wait_idle();
        repeat (60) @(negedge clk);
        chk(asleep_o == 1, "R12 power-down served", asleep_o, 1);
        chk(last_falls == PDC && vcnt == v0, "R12 start dropped", vcnt - v0, 0);
        pulse(wake_req_i);
        for (int i = 0; i < 400 && asleep_o; i++) @(negedge clk);
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_conv(10'h3FF, 4'h0, 1'b0, "R3 all ones");
        t_conv(10'h000, 4'h0, 1'b0, "R3 all zeros");
        t_conv(10'h2AA, 4'h0, 1'b0, "R3 alt A");
        t_conv(10'h155, 4'h0, 1'b0, "R3 alt B");
        t_conv(10'h200, 4'h0, 1'b0, "R3 lone MSB");
        t_conv(10'h155, 4'h8, 1'b0, "R4 lead bit0");
        t_conv(10'h0AA, 4'h1, 1'b0, "R4 lead bit3");
        t_conv(10'h3FF, 4'h0, 1'b1, "R5 short frame");
        t_held();
        t_pdn();
        t_asleep_ignore();
        t_wake();
        t_priority();
        chk(bad_width == 0, "R11 clock low width", bad_width, 0);
        chk(bad_quiet == 0, "R9 quiet time", bad_quiet, 0);
        report();
    end

endmodule